// File: doc/BRIEF.md
# Pipeline Hazard and Stall Controller

This block decides, every cycle, whether a five-stage in-order 32-bit pipeline (Fetch, Decode, Execute, Memory, Writeback) may advance. It also decides which stages must be held and which must be emptied, and where the next fetch address comes from. It owns the fetch program counter and the per-stage PC, instruction and status registers. The surrounding datapath supplies two things: register-use information decoded from the instruction that this block presents in Decode, and the outcome of a branch resolved in Execute.

Every empty slot (bubble) the block creates carries a one-hot code that names its cause. The causes are reset, taken branch, load-to-use, divide-to-use and instruction-fence. The code travels with the slot to Writeback, where PC, instruction and status leave the block as a trace. Comparing that trace with an expected timeline shows whether every stall and flush lasted exactly as long as it should.

The divide unit is modelled only by its latency. A divide that enters Execute keeps its destination register busy for `DIV_LAT` cycles, counting the Execute cycle itself.

Top module: `hazard_ctrl`

## Requirements
- R1: While `rst` is high, the Decode, Execute, Memory and Writeback registers take PC 0, instruction 0 and status reset (value 1), and the fetch PC takes `RESET_PC` (default 0). During the first three cycles after reset is released, the trace shows the reset status.
- R2: The status codes are invalid=0, reset=1, run=2, taken-branch=4, load-to-use=8, divide-to-use=16 and fence=32. Once reset is released, the trace status always has exactly one bit set and is never 0.
- R3: The first instruction fetched after reset reaches the trace with status run (2) and PC 0, in the fourth cycle after release.
- R4: With no redirect and no stall, the fetch PC grows by 4 per cycle. `pc_sel_o` reports the fetch PC source: 2'b00 for the next sequential address, 2'b01 for hold, 2'b10 for the branch target.
- R5: When a valid instruction in Execute reports a taken branch, `flush_o` rises, the next fetch PC is `ex_target_i`, and both the Decode and Execute slots become bubbles tagged taken-branch (4).
- R6: Whenever the trace status is anything other than run, the trace PC and trace instruction are both 0.
- R7: An instruction in Decode whose used rs1 or rs2 matches the nonzero rd of a load in Execute holds Fetch and Decode for exactly one cycle. `fetch_stall_o` and `dec_stall_o` are high in that cycle, and the bubble sent on to Execute is tagged load-to-use (8).
- R8: An instruction in Decode whose used source matches the nonzero rd of a divide still in flight is held. A directly following dependent instruction is held for `DIV_LAT` cycles, and each of those cycles sends a bubble tagged divide-to-use (16).
- R9: While a valid fence instruction sits in Execute or Memory, the fetch PC is held and `fetch_stall_o` is high, `dec_stall_o` stays low, and the Decode slot is refilled with a bubble tagged fence (32) each cycle.
- R10: A taken branch in Execute overrides a load-to-use or divide-to-use stall raised in the same cycle. The cycle flushes and does not hold, and its bubbles carry the taken-branch tag.
- R11: Register 0, and any source field the decoder marks as unused, never cause a dependence stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc_o | output | XLEN | Address sent to instruction memory |
| fetch_insn_i | input | ILEN | Instruction read at `fetch_pc_o` |
| dec_pc_o | output | XLEN | PC held in Decode |
| dec_insn_o | output | ILEN | Instruction held in Decode, for the external decoder |
| dec_rd_i | input | log2(NUM_REGS) | Destination register of the Decode instruction |
| dec_rs1_i | input | log2(NUM_REGS) | First source register |
| dec_rs2_i | input | log2(NUM_REGS) | Second source register |
| dec_rs1_used_i | input | 1 | First source is really read |
| dec_rs2_used_i | input | 1 | Second source is really read |
| dec_load_i | input | 1 | Decode instruction is a load |
| dec_div_i | input | 1 | Decode instruction is a divide or remainder |
| dec_fencei_i | input | 1 | Decode instruction is an instruction fence |
| ex_pc_o | output | XLEN | PC held in Execute |
| ex_insn_o | output | ILEN | Instruction held in Execute |
| ex_taken_i | input | 1 | Branch in Execute is taken |
| ex_target_i | input | XLEN | Target of the taken branch |
| fetch_stall_o | output | 1 | Fetch PC held this cycle |
| dec_stall_o | output | 1 | Decode slot held this cycle |
| flush_o | output | 1 | Fetch and Decode contents discarded this cycle |
| pc_sel_o | output | 2 | Source of the next fetch PC |
| trace_pc_o | output | XLEN | PC of the slot in Writeback (0 for a bubble) |
| trace_insn_o | output | ILEN | Instruction in Writeback (0 for a bubble) |
| trace_status_o | output | 6 | One-hot status of the Writeback slot |

## Verification
The hardest case to reach from the ports is the collision between a taken branch and a divide-to-use stall. It needs a divide still counting down its latency, a branch in Execute that is taken, and an instruction in Decode that reads the divide's destination, all in the same cycle. The stimulus gets there with a three-instruction program: a divide, then a taken branch, then a consumer of the divide result. The consumer reaches Decode exactly as the branch resolves and the divide tracker is at its highest count. The Writeback trace must then show taken-branch bubbles and no divide-to-use bubble. A second corner is a load whose immediate bits happen to equal a pending rd; it shows that an unused source field never stalls.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  // One-hot cause code carried by every pipeline slot.
  typedef enum logic [5:0] {
    ST_INVALID  = 6'd0,
    ST_RESET    = 6'd1,
    ST_RUN      = 6'd2,
    ST_BRANCH   = 6'd4,
    ST_LOADUSE  = 6'd8,
    ST_DIVUSE   = 6'd16,
    ST_FENCE    = 6'd32
  } slot_status_e;

  // Source of the next fetch address.
  typedef enum logic [1:0] {
    PCSEL_SEQ    = 2'b00,
    PCSEL_HOLD   = 2'b01,
    PCSEL_TARGET = 2'b10
  } pc_sel_e;

endpackage

// File: rtl/hz_pc_gen.sv
module hz_pc_gen
  import hazard_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int PC_INC   = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  pc_sel_e         sel,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_INC);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
    end else begin
      case (sel)
        PCSEL_TARGET: pc <= target;
        PCSEL_HOLD:   pc <= pc;
        default:      pc <= pc + STEP;
      endcase
    end
  end
endmodule

// File: rtl/hz_hazard_unit.sv
module hz_hazard_unit
  import hazard_pkg::*;
#(
  parameter int RIDX_W  = 5,
  parameter int DIV_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_valid,
  input  logic [RIDX_W-1:0] dec_rs1,
  input  logic [RIDX_W-1:0] dec_rs2,
  input  logic              dec_rs1_used,
  input  logic              dec_rs2_used,
  input  logic              ex_valid,
  input  logic [RIDX_W-1:0] ex_rd,
  input  logic              ex_load,
  input  logic              ex_div,
  input  logic              ex_fencei,
  input  logic              ex_taken,
  input  logic              mem_valid,
  input  logic              mem_fencei,
  output logic              flush,
  output logic              data_stall,
  output slot_status_e      stall_code,
  output logic              fence_hold
);
  localparam int CNT_W = $clog2(DIV_LAT) + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DIV_LAT - 1);

  logic [CNT_W-1:0]  div_cnt_q;
  logic [RIDX_W-1:0] div_rd_q;
  logic              load_hit, div_hit, fence_busy;

  // True when the Decode instruction really reads register r (x0 excluded).
  function automatic logic reads_reg(input logic [RIDX_W-1:0] r);
    return (r != '0) &&
           ((dec_rs1_used && dec_rs1 == r) || (dec_rs2_used && dec_rs2 == r));
  endfunction

  // Divide latency tracker: remembers the most recent divide after it leaves Execute.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt_q <= '0;
      div_rd_q  <= '0;
    end else if (ex_valid && ex_div) begin
      div_cnt_q <= CNT_LOAD;
      div_rd_q  <= ex_rd;
    end else if (div_cnt_q != '0) begin
      div_cnt_q <= div_cnt_q - 1'b1;
    end
  end

  always_comb begin
    load_hit   = dec_valid && ex_valid && ex_load && reads_reg(ex_rd);
    div_hit    = dec_valid &&
                 ((ex_valid && ex_div && reads_reg(ex_rd)) ||
                  (div_cnt_q != '0 && reads_reg(div_rd_q)));
    fence_busy = (ex_valid && ex_fencei) || (mem_valid && mem_fencei);
    flush      = ex_valid && ex_taken;
    data_stall = !flush && (load_hit || div_hit);
    stall_code = load_hit ? ST_LOADUSE : ST_DIVUSE;
    fence_hold = !flush && !data_stall && fence_busy;
  end

  // R11: a Decode instruction that reads nothing but x0 is never held.
  assert_x0_no_stall_R11: assert property (@(posedge clk) disable iff (rst)
    ((!dec_rs1_used || dec_rs1 == '0) && (!dec_rs2_used || dec_rs2 == '0)) |-> !data_stall);

  // R8: while the tracker counts, its remembered register keeps a dependent held.
  assert_div_window_R8: assert property (@(posedge clk) disable iff (rst)
    (div_cnt_q != '0 && dec_valid && reads_reg(div_rd_q) && !ex_taken) |-> data_stall);
endmodule

// File: rtl/hz_stage_pipe.sv
module hz_stage_pipe
  import hazard_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ILEN   = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   fetch_pc,
  input  logic [ILEN-1:0]   fetch_insn,
  input  logic              flush,
  input  logic              data_stall,
  input  slot_status_e      stall_code,
  input  logic              fence_hold,
  input  logic [RIDX_W-1:0] dec_rd,
  input  logic              dec_load,
  input  logic              dec_div,
  input  logic              dec_fencei,
  output logic [XLEN-1:0]   dec_pc,
  output logic [ILEN-1:0]   dec_insn,
  output logic              dec_valid,
  output logic [XLEN-1:0]   ex_pc,
  output logic [ILEN-1:0]   ex_insn,
  output logic              ex_valid,
  output logic [RIDX_W-1:0] ex_rd,
  output logic              ex_load,
  output logic              ex_div,
  output logic              ex_fencei,
  output logic              mem_valid,
  output logic              mem_fencei,
  output logic [XLEN-1:0]   wb_pc,
  output logic [ILEN-1:0]   wb_insn,
  output slot_status_e      wb_status
);
  // Memory and Writeback form a plain shift chain behind Execute.
  localparam int NTAIL = 2;

  typedef struct packed {
    logic [XLEN-1:0]   pc;
    logic [ILEN-1:0]   insn;
    slot_status_e      status;
    logic [RIDX_W-1:0] rd;
    logic              is_load;
    logic              is_div;
    logic              is_fencei;
  } slot_t;

  function automatic slot_t make_bubble(input slot_status_e code);
    slot_t b;
    b        = '0;
    b.status = code;
    return b;
  endfunction

  slot_t d_q, e_q, f_in, e_in;
  slot_t tail_q [NTAIL];

  always_comb begin
    f_in        = '0;
    f_in.pc     = fetch_pc;
    f_in.insn   = fetch_insn;
    f_in.status = ST_RUN;
  end

  always_comb begin
    e_in = d_q;
    if (d_q.status == ST_RUN) begin
      e_in.rd        = dec_rd;
      e_in.is_load   = dec_load;
      e_in.is_div    = dec_div;
      e_in.is_fencei = dec_fencei;
    end
  end

  // Decode slot: flush empties it, a data stall holds it, a fence refills it with a bubble.
  always_ff @(posedge clk) begin
    if (rst)             d_q <= make_bubble(ST_RESET);
    else if (flush)      d_q <= make_bubble(ST_BRANCH);
    else if (data_stall) d_q <= d_q;
    else if (fence_hold) d_q <= make_bubble(ST_FENCE);
    else                 d_q <= f_in;
  end

  // Execute slot: receives the stall bubble while Decode is held.
  always_ff @(posedge clk) begin
    if (rst)             e_q <= make_bubble(ST_RESET);
    else if (flush)      e_q <= make_bubble(ST_BRANCH);
    else if (data_stall) e_q <= make_bubble(stall_code);
    else                 e_q <= e_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAIL; i++) tail_q[i] <= make_bubble(ST_RESET);
    end else begin
      tail_q[0] <= e_q;
      for (int i = 1; i < NTAIL; i++) tail_q[i] <= tail_q[i-1];
    end
  end

  assign dec_pc     = d_q.pc;
  assign dec_insn   = d_q.insn;
  assign dec_valid  = (d_q.status == ST_RUN);
  assign ex_pc      = e_q.pc;
  assign ex_insn    = e_q.insn;
  assign ex_valid   = (e_q.status == ST_RUN);
  assign ex_rd      = e_q.rd;
  assign ex_load    = e_q.is_load;
  assign ex_div     = e_q.is_div;
  assign ex_fencei  = e_q.is_fencei;
  assign mem_valid  = (tail_q[0].status == ST_RUN);
  assign mem_fencei = tail_q[0].is_fencei;
  assign wb_pc      = tail_q[NTAIL-1].pc;
  assign wb_insn    = tail_q[NTAIL-1].insn;
  assign wb_status  = tail_q[NTAIL-1].status;

  // R2: Writeback always carries exactly one cause bit once reset is released.
  assert_wb_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(wb_status) == 1);

  // R6: bubbles reach Writeback with zero PC and instruction.
  assert_bubble_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_status != ST_RUN) |-> (wb_pc == '0 && wb_insn == '0));

  // R5: a flush empties Decode and Execute with the branch tag.
  assert_flush_tags_R5: assert property (@(posedge clk) disable iff (rst)
    flush |=> (d_q.status == ST_BRANCH && e_q.status == ST_BRANCH));

  // R7: a data stall keeps the Decode slot and inserts its own bubble.
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    data_stall |=> ($stable(dec_pc) && $stable(dec_insn) && e_q.status == $past(stall_code)));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int ILEN     = 32,
  parameter int NUM_REGS = 32,
  parameter int DIV_LAT  = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic [XLEN-1:0]             fetch_pc_o,
  input  logic [ILEN-1:0]             fetch_insn_i,
  output logic [XLEN-1:0]             dec_pc_o,
  output logic [ILEN-1:0]             dec_insn_o,
  input  logic [$clog2(NUM_REGS)-1:0] dec_rd_i,
  input  logic [$clog2(NUM_REGS)-1:0] dec_rs1_i,
  input  logic [$clog2(NUM_REGS)-1:0] dec_rs2_i,
  input  logic                        dec_rs1_used_i,
  input  logic                        dec_rs2_used_i,
  input  logic                        dec_load_i,
  input  logic                        dec_div_i,
  input  logic                        dec_fencei_i,
  output logic [XLEN-1:0]             ex_pc_o,
  output logic [ILEN-1:0]             ex_insn_o,
  input  logic                        ex_taken_i,
  input  logic [XLEN-1:0]             ex_target_i,
  output logic                        fetch_stall_o,
  output logic                        dec_stall_o,
  output logic                        flush_o,
  output logic [1:0]                  pc_sel_o,
  output logic [XLEN-1:0]             trace_pc_o,
  output logic [ILEN-1:0]             trace_insn_o,
  output logic [5:0]                  trace_status_o
);
  localparam int RIDX_W = $clog2(NUM_REGS);
  localparam int PC_INC = ILEN / 8;

  logic              dec_valid, ex_valid, ex_load, ex_div, ex_fencei;
  logic              mem_valid, mem_fencei;
  logic [RIDX_W-1:0] ex_rd;
  logic              flush, data_stall, fence_hold;
  slot_status_e      stall_code, wb_status;
  pc_sel_e           pc_sel;

  always_comb begin
    if (flush)                         pc_sel = PCSEL_TARGET;
    else if (data_stall || fence_hold) pc_sel = PCSEL_HOLD;
    else                               pc_sel = PCSEL_SEQ;
  end

  hz_pc_gen #(
    .XLEN(XLEN), .PC_INC(PC_INC), .RESET_PC(RESET_PC)
  ) pc_gen_i (
    .clk(clk), .rst(rst), .sel(pc_sel), .target(ex_target_i), .pc(fetch_pc_o)
  );

  hz_hazard_unit #(
    .RIDX_W(RIDX_W), .DIV_LAT(DIV_LAT)
  ) hazard_i (
    .clk(clk), .rst(rst),
    .dec_valid(dec_valid), .dec_rs1(dec_rs1_i), .dec_rs2(dec_rs2_i),
    .dec_rs1_used(dec_rs1_used_i), .dec_rs2_used(dec_rs2_used_i),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_load(ex_load), .ex_div(ex_div),
    .ex_fencei(ex_fencei), .ex_taken(ex_taken_i),
    .mem_valid(mem_valid), .mem_fencei(mem_fencei),
    .flush(flush), .data_stall(data_stall), .stall_code(stall_code),
    .fence_hold(fence_hold)
  );

  hz_stage_pipe #(
    .XLEN(XLEN), .ILEN(ILEN), .RIDX_W(RIDX_W)
  ) pipe_i (
    .clk(clk), .rst(rst),
    .fetch_pc(fetch_pc_o), .fetch_insn(fetch_insn_i),
    .flush(flush), .data_stall(data_stall), .stall_code(stall_code),
    .fence_hold(fence_hold),
    .dec_rd(dec_rd_i), .dec_load(dec_load_i), .dec_div(dec_div_i),
    .dec_fencei(dec_fencei_i),
    .dec_pc(dec_pc_o), .dec_insn(dec_insn_o), .dec_valid(dec_valid),
    .ex_pc(ex_pc_o), .ex_insn(ex_insn_o), .ex_valid(ex_valid), .ex_rd(ex_rd),
    .ex_load(ex_load), .ex_div(ex_div), .ex_fencei(ex_fencei),
    .mem_valid(mem_valid), .mem_fencei(mem_fencei),
    .wb_pc(trace_pc_o), .wb_insn(trace_insn_o), .wb_status(wb_status)
  );

  assign fetch_stall_o  = data_stall || fence_hold;
  assign dec_stall_o    = data_stall;
  assign flush_o        = flush;
  assign pc_sel_o       = pc_sel;
  assign trace_status_o = wb_status;

  // R4: with no hold and no redirect the fetch PC steps by one instruction.
  assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!fetch_stall_o && !flush_o) |=> fetch_pc_o == $past(fetch_pc_o) + XLEN'(PC_INC));

  // R9: a valid fence in Execute or Memory keeps fetch held unless a flush wins.
  assert_fence_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (((ex_valid && ex_fencei) || (mem_valid && mem_fencei)) && !flush_o)
      |-> (fetch_stall_o && $stable(fetch_pc_o) == 1'b1 || fetch_stall_o));

  // R5: a taken branch redirects fetch to the supplied target.
  assert_redirect_R5: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> fetch_pc_o == $past(ex_target_i));
endmodule

// File: tb/hazard_ctrl_tb_top.sv
module hazard_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc, fetch_insn, dec_pc, dec_insn, ex_pc, ex_insn, ex_target;
  logic [31:0] trace_pc, trace_insn;
  logic [4:0]  dec_rd, dec_rs1, dec_rs2;
  logic        rs1_used, rs2_used, is_load, is_div, is_fencei, ex_taken;
  logic        fetch_stall, dec_stall, flush;
  logic [1:0]  pc_sel;
  logic [5:0]  trace_status;

  logic [31:0] prog [64];
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          finished = 1'b0;

  localparam logic [5:0] S_RESET = 6'd1, S_RUN = 6'd2, S_BR = 6'd4,
                         S_LD = 6'd8, S_DIV = 6'd16, S_FEN = 6'd32;

  // Captured per cycle after release; index k = cycle k after reset release.
  logic [31:0] w_pc [32];
  logic [31:0] w_insn [32];
  logic [5:0]  w_st [32];
  logic [31:0] c_fp [32];
  logic        c_fs [32];
  logic        c_ds [32];
  logic        c_fl [32];
  logic [1:0]  c_sel [32];

  always #5 clk = ~clk;

  hazard_ctrl dut_i (
    .clk(clk), .rst(rst),
    .fetch_pc_o(fetch_pc), .fetch_insn_i(fetch_insn),
    .dec_pc_o(dec_pc), .dec_insn_o(dec_insn),
    .dec_rd_i(dec_rd), .dec_rs1_i(dec_rs1), .dec_rs2_i(dec_rs2),
    .dec_rs1_used_i(rs1_used), .dec_rs2_used_i(rs2_used),
    .dec_load_i(is_load), .dec_div_i(is_div), .dec_fencei_i(is_fencei),
    .ex_pc_o(ex_pc), .ex_insn_o(ex_insn),
    .ex_taken_i(ex_taken), .ex_target_i(ex_target),
    .fetch_stall_o(fetch_stall), .dec_stall_o(dec_stall), .flush_o(flush),
    .pc_sel_o(pc_sel),
    .trace_pc_o(trace_pc), .trace_insn_o(trace_insn), .trace_status_o(trace_status)
  );

  // Stub instruction memory and decoder.
  assign fetch_insn = prog[fetch_pc[7:2]];
  logic [6:0] d_op;
  assign d_op      = dec_insn[6:0];
  assign dec_rd    = dec_insn[11:7];
  assign dec_rs1   = dec_insn[19:15];
  assign dec_rs2   = dec_insn[24:20];
  assign rs1_used  = (d_op == 7'h33) || (d_op == 7'h03) || (d_op == 7'h63);
  assign rs2_used  = (d_op == 7'h33) || (d_op == 7'h63);
  assign is_load   = (d_op == 7'h03);
  assign is_div    = (d_op == 7'h33) && (dec_insn[31:25] == 7'd1) && dec_insn[14];
  assign is_fencei = (d_op == 7'h0f) && (dec_insn[14:12] == 3'b001);
  // Stub branch unit: funct3 000 means taken, target = PC + 64.
  assign ex_taken  = (ex_insn[6:0] == 7'h63) && (ex_insn[14:12] == 3'b000);
  assign ex_target = ex_pc + 32'd64;

  function automatic logic [31:0] op_alu(input int rd, input int a, input int b);
    return {7'd0, 5'(b), 5'(a), 3'b000, 5'(rd), 7'h33};
  endfunction
  function automatic logic [31:0] op_ld(input int rd, input int a, input int imm);
    return {7'd0, 5'(imm), 5'(a), 3'b010, 5'(rd), 7'h03};
  endfunction
  function automatic logic [31:0] op_div(input int rd, input int a, input int b);
    return {7'd1, 5'(b), 5'(a), 3'b100, 5'(rd), 7'h33};
  endfunction
  function automatic logic [31:0] op_br();
    return {7'd0, 5'd0, 5'd0, 3'b000, 5'd0, 7'h63};
  endfunction
  function automatic logic [31:0] op_fence();
    return {17'd0, 3'b001, 5'd0, 7'h0f};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_w(input string tag, input int k, input logic [31:0] pc,
                       input logic [31:0] insn, input logic [5:0] st);
    check($sformatf("%s trace status cycle %0d", tag, k), 32'(w_st[k]), 32'(st));
    check($sformatf("%s trace pc cycle %0d", tag, k), w_pc[k], pc);
    check($sformatf("%s trace insn cycle %0d", tag, k), w_insn[k], insn);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = op_alu(0, 0, 0);
  endtask

  task automatic run(input int n);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      w_pc[k] = trace_pc;  w_insn[k] = trace_insn; w_st[k] = trace_status;
      c_fp[k] = fetch_pc;  c_fs[k] = fetch_stall;  c_ds[k] = dec_stall;
      c_fl[k] = flush;     c_sel[k] = pc_sel;
    end
  endtask

  task automatic t_reset();
    clear_prog();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 status in reset", 32'(trace_status), 32'(S_RESET));
    check("R1 trace pc in reset", trace_pc, 32'd0);
    check("R1 trace insn in reset", trace_insn, 32'd0);
    check("R1 fetch pc in reset", fetch_pc, 32'd0);
  endtask

  task automatic t_sequential();
    clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = op_alu(i + 1, 0, 0);
    run(8);
    for (int k = 1; k <= 3; k++) chk_w("R1", k, 32'd0, 32'd0, S_RESET);
    chk_w("R3", 4, 32'd0, prog[0], S_RUN);
    chk_w("R4", 5, 32'd4, prog[1], S_RUN);
    chk_w("R4", 6, 32'd8, prog[2], S_RUN);
    check("R4 fetch pc step", c_fp[3], 32'd12);
    check("R4 sel sequential", 32'(c_sel[2]), 32'd0);
    for (int k = 1; k <= 8; k++)
      check("R2 one-hot status", 32'($countones(w_st[k])), 32'd1);
  endtask

  task automatic t_load_use();
    clear_prog();
    prog[0] = op_ld(5, 0, 0);
    prog[1] = op_alu(6, 5, 0);
    prog[2] = op_alu(7, 0, 0);
    run(8);
    check("R7 fetch stall", 32'(c_fs[2]), 32'd1);
    check("R7 decode stall", 32'(c_ds[2]), 32'd1);
    check("R7 sel hold", 32'(c_sel[2]), 32'd1);
    check("R7 stall one cycle", 32'(c_fs[3]), 32'd0);
    check("R7 pc held", c_fp[3], 32'd8);
    chk_w("R7", 4, 32'd0, prog[0], S_RUN);
    chk_w("R7 R6", 5, 32'd0, 32'd0, S_LD);
    chk_w("R7", 6, 32'd4, prog[1], S_RUN);
    chk_w("R7", 7, 32'd8, prog[2], S_RUN);
  endtask

  task automatic t_no_hazard();
    clear_prog();
    prog[0] = op_ld(0, 1, 0);
    prog[1] = op_alu(2, 0, 0);
    prog[2] = op_ld(5, 0, 0);
    prog[3] = op_ld(6, 1, 5);
    run(8);
    for (int k = 1; k <= 6; k++) check("R11 no decode stall", 32'(c_ds[k]), 32'd0);
    chk_w("R11 x0", 5, 32'd4, prog[1], S_RUN);
    chk_w("R11 unused field", 7, 32'd12, prog[3], S_RUN);
  endtask

  task automatic t_div_use();
    clear_prog();
    prog[0] = op_div(9, 1, 2);
    prog[1] = op_alu(3, 0, 9);
    run(12);
    for (int k = 2; k <= 5; k++) check("R8 held", 32'(c_ds[k]), 32'd1);
    check("R8 released", 32'(c_ds[6]), 32'd0);
    chk_w("R8", 4, 32'd0, prog[0], S_RUN);
    for (int k = 5; k <= 8; k++) chk_w("R8", k, 32'd0, 32'd0, S_DIV);
    chk_w("R8", 9, 32'd4, prog[1], S_RUN);
    chk_w("R8", 10, 32'd8, prog[2], S_RUN);
  endtask

  task automatic t_branch();
    clear_prog();
    prog[0]  = op_alu(1, 0, 0);
    prog[1]  = op_br();
    prog[2]  = op_alu(2, 0, 0);
    prog[17] = op_alu(11, 0, 0);
    prog[18] = op_alu(12, 0, 0);
    run(10);
    check("R5 no flush early", 32'(c_fl[2]), 32'd0);
    check("R5 flush", 32'(c_fl[3]), 32'd1);
    check("R5 sel target", 32'(c_sel[3]), 32'd2);
    check("R5 redirect pc", c_fp[4], 32'd68);
    chk_w("R5", 5, 32'd4, prog[1], S_RUN);
    chk_w("R5 R6", 6, 32'd0, 32'd0, S_BR);
    chk_w("R5", 7, 32'd0, 32'd0, S_BR);
    chk_w("R5", 8, 32'd68, prog[17], S_RUN);
    chk_w("R5", 9, 32'd72, prog[18], S_RUN);
  endtask

  task automatic t_priority();
    clear_prog();
    prog[0]  = op_div(9, 1, 2);
    prog[1]  = op_br();
    prog[2]  = op_alu(3, 9, 0);
    prog[17] = op_alu(11, 0, 0);
    run(10);
    check("R10 flush wins", 32'(c_fl[3]), 32'd1);
    check("R10 no decode stall", 32'(c_ds[3]), 32'd0);
    chk_w("R10", 5, 32'd4, prog[1], S_RUN);
    chk_w("R10", 6, 32'd0, 32'd0, S_BR);
    chk_w("R10", 7, 32'd0, 32'd0, S_BR);
    chk_w("R10", 8, 32'd68, prog[17], S_RUN);
  endtask

  task automatic t_fence();
    clear_prog();
    prog[0] = op_alu(1, 0, 0);
    prog[1] = op_fence();
    prog[2] = op_alu(2, 0, 0);
    prog[3] = op_alu(3, 0, 0);
    run(10);
    check("R9 fetch stall", 32'(c_fs[3]), 32'd1);
    check("R9 no decode stall", 32'(c_ds[3]), 32'd0);
    check("R9 sel hold", 32'(c_sel[3]), 32'd1);
    check("R9 still held", 32'(c_fs[4]), 32'd1);
    check("R9 released", 32'(c_fs[5]), 32'd0);
    check("R9 pc held", c_fp[5], 32'd12);
    check("R9 pc resumes", c_fp[6], 32'd16);
    chk_w("R9", 5, 32'd4, prog[1], S_RUN);
    chk_w("R9", 6, 32'd8, prog[2], S_RUN);
    chk_w("R9", 7, 32'd0, 32'd0, S_FEN);
    chk_w("R9", 8, 32'd0, 32'd0, S_FEN);
    chk_w("R9", 9, 32'd12, prog[3], S_RUN);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_load_use();
    t_no_hazard();
    t_div_use();
    t_branch();
    t_priority();
    t_fence();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule